// File: doc/BRIEF.md
# Tagged HDLC Transmit FIFO

This block buffers outgoing bytes between a processor write port and a bit-oriented serial transmitter. Every stored entry carries, besides its data byte, two marker bits: one marks the last byte of a packet, the other asks the transmitter to abort the frame at that byte. Software arms the markers through two set strobes ahead of the byte they belong to. The write that stores the byte then clears them, so each marker is attached to exactly one entry.

The read side is show-ahead. The oldest entry and its markers are always presented, and the transmitter takes it with a read strobe. A two-bit fill code reports the occupancy relative to a threshold that software selects from two levels. A one-cycle low-water pulse fires when the occupancy drops through that threshold, so software can refill the buffer before it runs dry. Writes to a full buffer are dropped and reported. Reads from an empty buffer are ignored. A synchronous reset returns the block to its empty state.

Top module: `tagged_tx_fifo`

## Requirements
- R1: The buffer holds up to 19 entries, and the 19 writes accepted after an empty state are all retained.
- R2: Each entry stores an end-of-packet marker and an abort marker. Each marker equals the matching pending bit OR the matching set strobe in the cycle the byte is written. The head outputs `rdEop` and `rdAbort` return these markers.
- R3: An accepted write clears both pending marker bits at that clock edge. A write that is dropped leaves them unchanged.
- R4: A set strobe raises its pending bit, which is visible on `eopPending` or `abortPending` from the next cycle. The bit holds until an accepted write or a reset.
- R5: `fillCode` is 00 when empty, 01 when 1 to threshold entries are held, 10 when above the threshold but below 19, and 11 at 19. The threshold is 4 when `thrSel`=0 and 14 when `thrSel`=1.
- R6: With `thrSel`=0, a clock edge that takes the occupancy from 5 to 4 makes `lowEvent` high for exactly the following cycle.
- R7: With `thrSel`=1, a clock edge that takes the occupancy from 15 to 14 makes `lowEvent` high for exactly the following cycle.
- R8: `lowEvent` stays low at every other edge, including when the occupancy rises, holds, or moves while below the threshold.
- R9: A write while 19 entries are held is dropped, even with a read in the same cycle. `overflow` is high for the following cycle, and the stored contents do not change.
- R10: A read while empty changes nothing. `rdEmpty` is high whenever no entry is held, and the head outputs then read zero.
- R11: A synchronous reset empties the buffer and clears both pending marker bits, `lowEvent` and `overflow`.
- R12: Entries leave in the order they were accepted. The head outputs show the oldest entry, and a read removes it at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe from the processor side |
| wrData | input | 8 | Byte to store |
| setEop | input | 1 | Arms the end-of-packet marker for the next written byte |
| setAbort | input | 1 | Arms the abort marker for the next written byte |
| thrSel | input | 1 | Threshold select: 0 gives level 4, 1 gives level 14 |
| rdEn | input | 1 | Read strobe from the transmitter, removes the head entry |
| rdData | output | 8 | Head data byte, zero when empty |
| rdEop | output | 1 | End-of-packet marker of the head entry |
| rdAbort | output | 1 | Abort marker of the head entry |
| rdEmpty | output | 1 | No entry held |
| fillCode | output | 2 | Fill state code |
| lowEvent | output | 1 | One-cycle low-water pulse |
| overflow | output | 1 | One-cycle pulse after a dropped write |
| eopPending | output | 1 | End-of-packet marker armed |
| abortPending | output | 1 | Abort marker armed |

## Verification
A wrong occupancy count shows up within one cycle in `fillCode` and `rdEmpty`. Later it causes a missed or extra `lowEvent`, or a spurious `overflow`. A misplaced pointer or a wrongly latched marker is only exposed when the damaged entry reaches the head, which can be up to 19 reads later. The bench therefore compares the head byte and its markers on every cycle against a queue model. A pending bit that fails to clear shows on `eopPending` or `abortPending` one cycle after the write, and it also shows when the next entry is read.

// File: rtl/tagtx_pkg.sv
package tagtx_pkg;
  // Strobes the control module issues to the datapath each cycle
  typedef struct packed {
    logic push;      // store wrData this edge
    logic pop;       // retire head entry this edge
    logic tagEop;    // end-of-packet marker for the pushed entry
    logic tagAbort;  // abort marker for the pushed entry
  } fifoStrobe_t;
endpackage

// File: rtl/tagtx_dp.sv
module tagtx_dp
  import tagtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              empty,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEop,
  output logic              rdAbort
);
  localparam int ENTRY_W = DATA_W + 2;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [ENTRY_W-1:0] headEntry;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= {strobe.tagEop, strobe.tagAbort, wrData};
  end

  always_comb begin
    headEntry = empty ? '0 : mem[rdPtr];
    rdData    = headEntry[DATA_W-1:0];
    rdAbort   = headEntry[DATA_W];
    rdEop     = headEntry[DATA_W+1];
  end

  // R12
  rd_advance_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.pop |=> rdPtr != $past(rdPtr) || DEPTH == 1);

  // R1
  wr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.push |=> wrPtr != $past(wrPtr) || DEPTH == 1);
endmodule

// File: rtl/tagtx_ctrl.sv
module tagtx_ctrl
  import tagtx_pkg::*;
#(
  parameter int DEPTH      = 19,
  parameter int LOW_LEVEL  = 4,
  parameter int HIGH_LEVEL = 14
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        setEop,
  input  logic        setAbort,
  input  logic        thrSel,
  output fifoStrobe_t strobe,
  output logic        empty,
  output logic [1:0]  fillCode,
  output logic        lowEvent,
  output logic        overflow,
  output logic        eopPend,
  output logic        abortPend
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LOW_THR  = CNT_W'(LOW_LEVEL);
  localparam logic [CNT_W-1:0] HIGH_THR = CNT_W'(HIGH_LEVEL);

  logic [CNT_W-1:0] count, countNext, thr;
  logic             full;

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign thr   = thrSel ? HIGH_THR : LOW_THR;

  always_comb begin
    strobe.push     = wrEn && !full;
    strobe.pop      = rdEn && !empty;
    strobe.tagEop   = eopPend | setEop;
    strobe.tagAbort = abortPend | setAbort;
    countNext = count;
    if (strobe.push && !strobe.pop)      countNext = count + 1'b1;
    else if (strobe.pop && !strobe.push) countNext = count - 1'b1;
  end

  always_comb begin
    if (empty)          fillCode = 2'b00;
    else if (count <= thr) fillCode = 2'b01;
    else if (!full)     fillCode = 2'b10;
    else                fillCode = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      eopPend   <= 1'b0;
      abortPend <= 1'b0;
      lowEvent  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      count     <= countNext;
      eopPend   <= strobe.push ? 1'b0 : strobe.tagEop;
      abortPend <= strobe.push ? 1'b0 : strobe.tagAbort;
      lowEvent  <= (count == thr + 1'b1) && (countNext == thr);
      overflow  <= wrEn && full;
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R9
  overflow_src_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(full) && $past(wrEn) && $stable(count) || $past(rdEn));

  // R3
  tag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.push |=> !eopPend && !abortPend);

  // R8
  low_edge_chk: assert property (@(posedge clk) disable iff (rst)
    lowEvent |-> $past(count) == count + 1'b1);

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> empty && !eopPend && !abortPend && !lowEvent && !overflow);
endmodule

// File: rtl/tagged_tx_fifo.sv
module tagged_tx_fifo
  import tagtx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 19,
  parameter int LOW_LEVEL  = 4,
  parameter int HIGH_LEVEL = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              setEop,
  input  logic              setAbort,
  input  logic              thrSel,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEop,
  output logic              rdAbort,
  output logic              rdEmpty,
  output logic [1:0]        fillCode,
  output logic              lowEvent,
  output logic              overflow,
  output logic              eopPending,
  output logic              abortPending
);
  fifoStrobe_t strobe;

  tagtx_ctrl #(
    .DEPTH(DEPTH), .LOW_LEVEL(LOW_LEVEL), .HIGH_LEVEL(HIGH_LEVEL)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn),
    .setEop(setEop), .setAbort(setAbort), .thrSel(thrSel),
    .strobe(strobe), .empty(rdEmpty), .fillCode(fillCode),
    .lowEvent(lowEvent), .overflow(overflow),
    .eopPend(eopPending), .abortPend(abortPending)
  );

  tagtx_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .empty(rdEmpty), .rdData(rdData), .rdEop(rdEop), .rdAbort(rdAbort)
  );
endmodule

// File: tb/tagged_tx_fifo_bench.sv
`timescale 1ns/1ps
module tagged_tx_fifo_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 0, setEop = 0, setAbort = 0, thrSel = 0, rdEn = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rdEop, rdAbort, rdEmpty, lowEvent, overflow, eopPending, abortPending;
  logic [1:0] fillCode;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [9:0] q[$];
  bit mEop = 0, mAbort = 0, mLow = 0, mOvf = 0;

  always #2.5 clk = ~clk;

  tagged_tx_fifo u_tagged_tx_fifo (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .setEop(setEop),
    .setAbort(setAbort), .thrSel(thrSel), .rdEn(rdEn), .rdData(rdData),
    .rdEop(rdEop), .rdAbort(rdAbort), .rdEmpty(rdEmpty), .fillCode(fillCode),
    .lowEvent(lowEvent), .overflow(overflow), .eopPending(eopPending),
    .abortPending(abortPending)
  );

  function automatic logic [1:0] expCode(int n, bit ts);
    int t = ts ? 14 : 4;
    if (n == 0) return 2'b00;
    if (n <= t) return 2'b01;
    if (n < 19) return 2'b10;
    return 2'b11;
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    logic [9:0] head = (q.size() == 0) ? 10'd0 : q[0];
    cmp(q.size() == 19 ? "R1" : "R5", "fillCode", fillCode, expCode(q.size(), thrSel));
    cmp("R10", "rdEmpty", rdEmpty, q.size() == 0);
    cmp("R12", "rdData", rdData, head[7:0]);
    cmp("R2", "rdEop", rdEop, head[9]);
    cmp("R2", "rdAbort", rdAbort, head[8]);
    cmp(mLow ? (thrSel ? "R7" : "R6") : "R8", "lowEvent", lowEvent, mLow);
    cmp("R9", "overflow", overflow, mOvf);
    cmp("R3", "eopPending", eopPending, mEop);
    cmp("R4", "abortPending", abortPending, mAbort);
  endtask

  // Drive one cycle at the falling edge, advance the model, check at the next falling edge
  task automatic tick(bit w, logic [7:0] d, bit se, bit sa, bit r, bit ts);
    int oldN = q.size();
    int t = ts ? 14 : 4;
    bit full = (oldN == 19);
    bit push = w && !full;
    bit pop = r && oldN > 0;
    bit tE = mEop | se;
    bit tA = mAbort | sa;
    wrEn = w; wrData = d; setEop = se; setAbort = sa; rdEn = r; thrSel = ts;
    if (pop) void'(q.pop_front());
    if (push) q.push_back({tE, tA, d});
    mOvf = w && full;
    mLow = (oldN == t + 1) && (q.size() == t);
    mEop = push ? 1'b0 : tE;
    mAbort = push ? 1'b0 : tA;
    @(posedge clk);
    @(negedge clk);
    checkAll();
  endtask

  task automatic doReset();
    rst = 1; wrEn = 0; rdEn = 0; setEop = 0; setAbort = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    q.delete(); mEop = 0; mAbort = 0; mLow = 0; mOvf = 0;
    checkAll(); // R11
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    doReset();
    // R4: arm markers without writing, they must hold
    tick(0, 8'h00, 1, 0, 0, 0);
    tick(0, 8'h00, 0, 1, 0, 0);
    tick(0, 8'h00, 0, 0, 0, 0);
    // R2 R3: write consumes them
    tick(1, 8'hA5, 0, 0, 0, 0);
    // R2: set strobe in the write cycle applies to that byte
    tick(1, 8'h3C, 1, 0, 0, 0);
    // R1 R9: fill to full, then overflow with armed marker (R3 kept)
    for (int i = 0; i < 17; i++) tick(1, 8'(i + 16), 0, 0, 0, 1);
    tick(0, 8'h00, 0, 1, 0, 1);
    tick(1, 8'hEE, 0, 0, 0, 1);
    tick(1, 8'hEF, 0, 0, 1, 1);
    // R7: drain through 15 to 14
    for (int i = 0; i < 8; i++) tick(0, 8'h00, 0, 0, 1, 1);
    // R8: refill upward through threshold, then hold
    for (int i = 0; i < 3; i++) tick(1, 8'(i), 0, 0, 0, 1);
    tick(0, 8'h00, 0, 0, 0, 1);
    // R6: drain completely with default threshold, then R10 reads on empty
    for (int i = 0; i < 22; i++) tick(0, 8'h00, 0, 0, 1, 0);
    // R11: reset with content and armed markers
    for (int i = 0; i < 6; i++) tick(1, 8'(i * 7), i == 3, 0, 0, 0);
    tick(0, 8'h00, 1, 1, 0, 0);
    doReset();
    // Random phases with varying write/read balance
    for (int ph = 0; ph < 8; ph++) begin
      int wp = 20 + (ph % 4) * 20;
      bit ts = ph[1];
      for (int c = 0; c < 500; c++) begin
        tick(($urandom % 100) < wp, 8'($urandom), ($urandom % 8) == 0,
             ($urandom % 12) == 0, ($urandom % 100) < (100 - wp),
             ($urandom % 64) == 0 ? !ts : ts);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule